// File: doc/BRIEF.md
# Set-Associative Cache Miss Classifier

This block is a tag-only model of a small two-way set-associative cache with 16-bit byte addresses. It holds 32 bytes as four sets of two 4-byte lines. Each cycle it may accept one address. It looks the address up and, one cycle later, reports a hit or a miss. Data storage, refills from memory and write policy are outside the block. It keeps only tags, valid bits, per-set replacement state and the extra state it needs to explain misses.

Every miss is given one of three types, using two pieces of side state. A first-touch bitmap says whether a line has ever been referenced. An eight-line fully associative shadow directory with true LRU order says whether a cache of the same total size with no set restriction would have held the line. A line that was never referenced is a cold miss. A miss that the shadow directory also takes is a capacity miss. Any other miss is a conflict miss. A synchronous clear empties the tag store, the shadow directory and the touch record. The block is meant for performance monitors and for cache-sizing studies run in hardware.

Top module: `cmc_miss_classifier`

## Requirements
- R1: Out of reset all outputs are 0 and the cache is empty, so the first access to any line is a cold miss.
- R2: The result of an access accepted at a clock edge appears on the outputs after that edge and holds for one cycle. In a cycle with no accepted access, hit_o, miss_o and miss_type_o are all 0.
- R3: Address bits [1:0] are the byte offset, bits [3:2] select the set and bits [15:4] form the tag. Two addresses that differ only in bits [1:0] refer to the same line.
- R4: Each set holds two lines with one LRU bit. A miss fills an invalid way before any valid way is evicted. With both ways valid, the miss replaces the way used least recently, and a hit makes its way the most recent.
- R5: miss_type_o encodes 00 = hit or no result, 01 = cold, 10 = capacity, 11 = conflict. hit_o and miss_o are never 1 together.
- R6: A miss is cold when its line address (addr[15:2]) has not been referenced since reset or the last clear.
- R7: A miss that is not cold is a capacity miss when an 8-line fully associative LRU directory would also miss. That directory is updated on every accepted access, hit or miss.
- R8: A miss that is neither cold nor capacity is a conflict miss.
- R9: While clr_i is 1, the tag store, shadow directory and touch record are emptied at the clock edge. An access presented in the same cycle is dropped and gives no result.
- R10: Back-to-back accesses see the state updated by the access in the previous cycle, including accesses to the same set.
- R11: The touch record covers line addresses below 2^TRACK_W (byte addresses below 1024 by default). Every accepted address must lie in that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of all tracking state |
| valid_i | input | 1 | Address valid this cycle |
| addr_i | input | 16 | Byte address |
| hit_o | output | 1 | Previous access hit |
| miss_o | output | 1 | Previous access missed |
| miss_type_o | output | 2 | Miss type of previous access |

## Verification
The assertions take for granted that every accepted address lies inside the tracked line range (R11), because the touch record has no entry above it. An input assertion checks this. The bench draws its random addresses from the first 256 bytes and keeps every directed address below 1024. The small random pool packs many lines into each set, so conflict and capacity misses both occur often. Occasional idle cycles and rare clears are mixed into the stream.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    MT_NONE = 2'b00,
    MT_COLD = 2'b01,
    MT_CAP  = 2'b10,
    MT_CONF = 2'b11
  } miss_type_e;
endpackage

// File: rtl/cmc_tag_store.sv
module cmc_tag_store #(
  parameter int TAG_W = 12,
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic [SETS-1:0]  lru_q;  // 1: way 1 is least recent
  logic [1:0]       way_hit;
  logic             victim;
  logic [2*SETS-1:0] vld_flat;

  always_comb begin
    for (int w = 0; w < 2; w++)
      way_hit[w] = vld_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
    hit_o = |way_hit;
    if (!vld_q[idx_i][0])      victim = 1'b0;
    else if (!vld_q[idx_i][1]) victim = 1'b1;
    else                       victim = lru_q[idx_i];
    for (int s = 0; s < SETS; s++) vld_flat[2*s +: 2] = vld_q[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lru_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < 2; w++) tag_q[s][w] <= '0;
      end
    end else if (clr_i) begin
      lru_q <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (acc_i) begin
      if (hit_o) begin
        lru_q[idx_i] <= ~way_hit[1];
      end else begin
        tag_q[idx_i][victim] <= tag_i;
        vld_q[idx_i][victim] <= 1'b1;
        lru_q[idx_i]         <= ~victim;
      end
    end
  end

  AST_WAY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(way_hit)); // R4
  AST_FILL_INVALID_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i && !hit_o && (vld_q[idx_i] != 2'b11))
    |=> ($countones(vld_flat) == $past($countones(vld_flat)) + 1)); // R4
  AST_HIT_KEEPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i && hit_o) |=> $stable(vld_flat)); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_flat == '0)); // R9
endmodule

// File: rtl/cmc_shadow_dir.sv
module cmc_shadow_dir #(
  parameter int LINE_W = 14,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              acc_i,
  input  logic [LINE_W-1:0] line_i,
  output logic              hit_o
);
  localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // entry 0 is most recent
  logic [LINE_W-1:0] ent_q [DEPTH];
  logic [DEPTH-1:0]  ev_q;
  logic [DEPTH-1:0]  match;
  logic [POS_W-1:0]  pos;

  always_comb begin
    pos = POS_W'(DEPTH - 1);
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = ev_q[i] && (ent_q[i] == line_i);
      if (match[i]) pos = POS_W'(i);
    end
    hit_o = |match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (clr_i) begin
      ev_q <= '0;
    end else if (acc_i) begin
      ent_q[0] <= line_i;
      ev_q[0]  <= 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
        if (i <= int'(pos)) begin
          ent_q[i] <= ent_q[i-1];
          ev_q[i]  <= ev_q[i-1];
        end
      end
    end
  end

  AST_SHADOW_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match)); // R7
  AST_SHADOW_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i) |=> (ev_q[0] && ent_q[0] == $past(line_i))); // R7
endmodule

// File: rtl/cmc_touch_map.sv
module cmc_touch_map #(
  parameter int TRACK_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               acc_i,
  input  logic [TRACK_W-1:0] line_i,
  output logic               seen_o
);
  localparam int NLINES = 1 << TRACK_W;

  logic [NLINES-1:0] map_q;

  assign seen_o = map_q[line_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     map_q <= '0;
    else if (clr_i)  map_q <= '0;
    else if (acc_i)  map_q[line_i] <= 1'b1;
  end

  AST_TOUCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !clr_i) |=> (!(line_i == $past(line_i)) || clr_i || seen_o)); // R6
endmodule

// File: rtl/cmc_miss_classifier.sv
module cmc_miss_classifier
  import cmc_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int OFF_W        = 2,
  parameter int IDX_W        = 2,
  parameter int TRACK_W      = 8,
  parameter int SHADOW_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [1:0]        miss_type_o
);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TAG_W  = LINE_W - IDX_W;

  logic              acc;
  logic [LINE_W-1:0] line;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              tag_hit, shadow_hit, seen;
  miss_type_e        kind_d, kind_q;
  logic              hit_q, miss_q;

  assign acc  = valid_i && !clr_i;
  assign line = addr_i[ADDR_W-1:OFF_W];
  assign idx  = line[IDX_W-1:0];
  assign tag  = line[LINE_W-1:IDX_W];

  cmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) i_tags (
    .clk_i, .rst_ni, .clr_i, .acc_i(acc), .idx_i(idx), .tag_i(tag), .hit_o(tag_hit)
  );

  cmc_shadow_dir #(.LINE_W(LINE_W), .DEPTH(SHADOW_DEPTH)) i_shadow (
    .clk_i, .rst_ni, .clr_i, .acc_i(acc), .line_i(line), .hit_o(shadow_hit)
  );

  cmc_touch_map #(.TRACK_W(TRACK_W)) i_touch (
    .clk_i, .rst_ni, .clr_i, .acc_i(acc), .line_i(line[TRACK_W-1:0]), .seen_o(seen)
  );

  always_comb begin
    if (tag_hit)         kind_d = MT_NONE;
    else if (!seen)      kind_d = MT_COLD;
    else if (!shadow_hit) kind_d = MT_CAP;
    else                 kind_d = MT_CONF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      kind_q <= MT_NONE;
    end else begin
      hit_q  <= acc && tag_hit;
      miss_q <= acc && !tag_hit;
      kind_q <= acc ? kind_d : MT_NONE;
    end
  end

  assign hit_o       = hit_q;
  assign miss_o      = miss_q;
  assign miss_type_o = kind_q;

  AST_ADDR_TRACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (addr_i[ADDR_W-1:OFF_W+TRACK_W] == '0)); // R11
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R5
  AST_HIT_NO_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (miss_type_o == 2'b00)); // R5
  AST_MISS_TYPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (miss_type_o != 2'b00)); // R5
  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i) |=> (hit_o || miss_o)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && !clr_i) |=> (!hit_o && !miss_o && miss_type_o == 2'b00)); // R9
  AST_UNSEEN_IS_COLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i && !seen) |=> (miss_o && miss_type_o == 2'b01)); // R6
endmodule

// File: tb/test_cmc_miss_classifier.sv
`timescale 1ns/1ps
module test_cmc_miss_classifier;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, valid = 1'b0;
  logic [15:0] addr = '0;
  logic hit, miss;
  logic [1:0] mtype;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cmc_miss_classifier i_cmc_miss_classifier (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .valid_i(valid), .addr_i(addr),
    .hit_o(hit), .miss_o(miss), .miss_type_o(mtype)
  );

  // reference state
  int m_tag [4][2];
  bit m_vld [4][2];
  bit m_lru [4];
  int sh_line [8];
  bit sh_v [8];
  bit touched [256];

  function automatic void model_clear();
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_vld[s][w] = 0; m_tag[s][w] = 0; end
    end
    for (int i = 0; i < 8; i++) begin sh_v[i] = 0; sh_line[i] = 0; end
    for (int i = 0; i < 256; i++) touched[i] = 0;
  endfunction

  // returns {hit, miss, type[1:0]}
  function automatic logic [3:0] model_access(int a);
    int ln, s, t, p, vic;
    bit h0, h1, sh;
    logic [1:0] ty;
    ln = a >> 2; s = ln & 3; t = ln >> 2;
    h0 = m_vld[s][0] && m_tag[s][0] == t;
    h1 = m_vld[s][1] && m_tag[s][1] == t;
    sh = 0; p = 7;
    for (int i = 0; i < 8; i++) if (sh_v[i] && sh_line[i] == ln) begin sh = 1; p = i; end
    if (h0 || h1) ty = 2'b00;
    else if (!touched[ln]) ty = 2'b01;
    else if (!sh) ty = 2'b10;
    else ty = 2'b11;
    if (h0 || h1) m_lru[s] = h0;
    else begin
      vic = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : int'(m_lru[s]));
      m_tag[s][vic] = t; m_vld[s][vic] = 1; m_lru[s] = (vic == 0);
    end
    for (int i = 7; i > 0; i--) if (i <= p) begin sh_line[i] = sh_line[i-1]; sh_v[i] = sh_v[i-1]; end
    sh_line[0] = ln; sh_v[0] = 1;
    touched[ln] = 1;
    return {h0 || h1, !(h0 || h1), ty};
  endfunction

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if ({hit, miss, mtype} !== exp) begin
      fails++;
      $display("FAIL %s: got hit=%0b miss=%0b type=%02b, expected hit=%0b miss=%0b type=%02b",
               req, hit, miss, mtype, exp[3], exp[2], exp[1:0]);
    end
  endtask

  // call at a negedge; leaves at the next negedge after checking
  task automatic acc(int a, string req, int want = -1);
    logic [3:0] e;
    e = model_access(a);
    valid = 1'b1; addr = 16'(a);
    @(negedge clk);
    check(req, e);
    if (want >= 0) check({req, "_direct"}, {want == 0, want != 0, 2'(want)});
    valid = 1'b0;
  endtask

  task automatic idle(string req);
    valid = 1'b0;
    @(negedge clk);
    check(req, 4'b0000);
  endtask

  task automatic do_clear(bit with_access);
    clr = 1'b1; valid = with_access; addr = 16'h0004;
    @(negedge clk);
    clr = 1'b0; valid = 1'b0;
    model_clear();
    check("R9_clear_drops_access", 4'b0000);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    model_clear();
    repeat (3) @(negedge clk);
    check("R1_reset_outputs", 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R2_idle");

    // cold fills, offsets, hits
    acc(8,  "R1_cold", 1);
    acc(3,  "R6_cold", 1);
    acc(9,  "R3_same_line", 0);
    acc(7,  "R6_cold");
    acc(15, "R6_cold");
    acc(20, "R4_second_way", 1);
    acc(22, "R3_offset_hit", 0);
    acc(2,  "R10_hit");
    acc(6,  "R4_hit");
    acc(0,  "R3_hit", 0);
    idle("R2_idle_after_burst");

    // back-to-back same set
    acc(16'h100, "R10_fill");
    acc(16'h110, "R10_fill2");
    acc(16'h100, "R10_back_to_back", 0);

    // LRU and conflict
    acc(16'h200, "R4_fill");
    acc(16'h210, "R4_fill");
    acc(16'h200, "R4_hit", 0);
    acc(16'h220, "R4_evict_lru", 1);
    acc(16'h200, "R4_mru_kept", 0);
    acc(16'h210, "R8_conflict", 3);

    // capacity after clear
    do_clear(1'b1);
    acc(16'h100, "R9_cold_after_clear", 1);
    do_clear(1'b0);
    for (int i = 0; i < 9; i++) acc(i * 4, "R7_fill");
    acc(0, "R7_capacity", 2);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) idle("R2_random_idle");
      else if (r == 8) do_clear(1'($urandom_range(0, 1)));
      else acc(int'($urandom_range(0, 255)), "R5_random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule